// File: doc/BRIEF.md
# Lockable protection register file

This block is the storage side of a physical memory protection unit. It holds a configurable number of protection entries, each made of one configuration byte and one raw address register. The raw address register holds a physical address with its two lowest bits dropped, that is, the address shifted right by two. Software-side logic writes one entry at a time through a single write port. It names the entry, says whether the configuration byte or the address is targeted, and supplies the data. One cycle later the block reports whether the write was taken.

Protection logic elsewhere in the chip reads every entry's configuration and raw address in parallel from the exported buses. It also reads two summary signals: how many entries are armed (matching mode other than off) and whether any entry is locked. A clear input disarms and unlocks all entries at once. It leaves their permission bits and addresses alone. Decoding regions and checking accesses are left to the consumer.

Configuration byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 matching mode (0 off, 1 top-of-range, 2 four-byte aligned, 3 power-of-two aligned), bits 6:5 reserved, bit 7 lock.

Top module: `guard_bank`

## Requirements
- R1: A write strobe whose index is greater than or equal to NUM_ENT is rejected and changes no entry.
- R2: A configuration write to an entry whose lock bit (bit 7) is set is rejected and leaves that entry unchanged.
- R3: An address write to an entry whose own lock bit is set is rejected and leaves its address unchanged.
- R4: An address write to entry i is also rejected when entry i+1 exists, has its lock bit set, and has matching mode 1 (top-of-range). A locked neighbour in another mode, an unlocked top-of-range neighbour, or no neighbour (last entry) does not block it.
- R5: An accepted configuration write stores the low byte of the write data with bits 6:5 forced to zero.
- R6: An accepted address write stores the low RAW_W bits of the write data as the raw address (physical address bits from bit 2 upward).
- R7: wr_done_o is high exactly in the cycle after each write strobe and low otherwise. In that cycle wr_ok_o is 1 for an accepted write and 0 for a rejected one. wr_ok_o is 0 whenever wr_done_o is 0.
- R8: A clear pulse zeroes the matching-mode bits (4:3) and the lock bit (7) of every entry. It keeps bits 2:0 and all raw addresses. A write strobed in the same cycle as a clear is rejected.
- R9: active_cnt_o equals the number of entries whose matching mode is not 0, and any_lock_o is the OR of all lock bits. Both reflect a write or clear in the cycle after its strobe.
- R10: After reset, all configuration bytes and raw addresses are zero, and wr_done_o, wr_ok_o, active_cnt_o and any_lock_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Disarm and unlock all entries |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | IDX_W | Entry index of the write |
| wr_sel_addr_i | input | 1 | 1 targets the raw address, 0 the configuration byte |
| wr_data_i | input | RAW_W | Write data (configuration uses bits 7:0) |
| wr_done_o | output | 1 | Write status valid |
| wr_ok_o | output | 1 | Write accepted |
| cfg_o | output | NUM_ENT*8 | All configuration bytes, entry i at bits 8i+7:8i |
| addr_o | output | NUM_ENT*RAW_W | All raw addresses, entry i at slice i |
| active_cnt_o | output | CNT_W | Number of armed entries |
| any_lock_o | output | 1 | Some entry is locked |

## Verification
The bench targets the neighbour rule. It writes an address below a locked top-of-range entry, below a locked entry in another mode, and into the last entry. A design that looks at the wrong neighbour, ignores the mode, or reads past the end would accept or refuse the wrong one of these. It also strikes indices just past the entry count, where a truncated compare would alias onto a real entry. It then checks that a clear keeps the permission bits and addresses, and that a write in the clear cycle is refused. A design that wiped whole bytes, or let the write through, would show changed outputs. The summaries are compared after every operation, so a count that skips an armed entry or a stale lock flag shows up right away.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int CFG_W = 8;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  function automatic amode_e cfg_mode(input logic [CFG_W-1:0] c);
    return amode_e'(c[4:3]);
  endfunction

  function automatic logic cfg_locked(input logic [CFG_W-1:0] c);
    return c[7];
  endfunction

  // byte as stored after an accepted write: reserved bits dropped
  function automatic logic [CFG_W-1:0] cfg_store(input logic [CFG_W-1:0] c);
    return {c[7], 2'b00, c[4:0]};
  endfunction

  // byte after a clear: mode and lock removed, permissions kept
  function automatic logic [CFG_W-1:0] cfg_disarm(input logic [CFG_W-1:0] c);
    return {1'b0, c[6:5], 2'b00, c[2:0]};
  endfunction
endpackage

// File: rtl/guard_entry.sv
module guard_entry
  import guard_pkg::*;
#(
  parameter int RAW_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             cfg_we_i,
  input  logic             addr_we_i,
  input  logic [RAW_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [RAW_W-1:0] addr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o <= '0;
    end else if (clr_i) begin
      cfg_o <= cfg_disarm(cfg_o);
    end else if (cfg_we_i) begin
      cfg_o <= cfg_store(wdata_i[CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o <= '0;
    end else if (addr_we_i) begin
      addr_o <= wdata_i;
    end
  end
endmodule

// File: rtl/guard_summary.sv
module guard_summary
  import guard_pkg::*;
#(
  parameter int NUM_ENT = 6,
  parameter int CNT_W   = 3
) (
  input  logic [NUM_ENT*CFG_W-1:0] cfg_i,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     lock_o
);
  always_comb begin
    cnt_o  = '0;
    lock_o = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (cfg_mode(cfg_i[i*CFG_W +: CFG_W]) != AM_OFF) cnt_o = cnt_o + 1'b1;
      lock_o = lock_o | cfg_locked(cfg_i[i*CFG_W +: CFG_W]);
    end
  end
endmodule

// File: rtl/guard_bank.sv
module guard_bank
  import guard_pkg::*;
#(
  parameter int NUM_ENT = 6,
  parameter int RAW_W   = 30,
  parameter int IDX_W   = 4,
  localparam int CNT_W  = $clog2(NUM_ENT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic                     wr_sel_addr_i,
  input  logic [RAW_W-1:0]         wr_data_i,
  output logic                     wr_done_o,
  output logic                     wr_ok_o,
  output logic [NUM_ENT*CFG_W-1:0] cfg_o,
  output logic [NUM_ENT*RAW_W-1:0] addr_o,
  output logic [CNT_W-1:0]         active_cnt_o,
  output logic                     any_lock_o
);
  // named internal events
  logic               wr_go;
  logic [NUM_ENT-1:0] wr_hit;
  logic [NUM_ENT-1:0] nbr_tor_lock;
  logic [NUM_ENT-1:0] wr_blocked;
  logic [NUM_ENT-1:0] wr_take;
  logic               wr_accept;

  assign wr_go = wr_en_i & ~clr_i;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic [CFG_W-1:0] cfg_q;
    logic [RAW_W-1:0] addr_q;

    assign wr_hit[i] = wr_go && (wr_idx_i == IDX_W'(i));

    if (i < NUM_ENT - 1) begin : g_nbr
      assign nbr_tor_lock[i] = cfg_locked(cfg_o[(i+1)*CFG_W +: CFG_W]) &&
                               (cfg_mode(cfg_o[(i+1)*CFG_W +: CFG_W]) == AM_TOR);
    end else begin : g_last
      assign nbr_tor_lock[i] = 1'b0;
    end

    assign wr_blocked[i] = cfg_locked(cfg_q) | (wr_sel_addr_i & nbr_tor_lock[i]);
    assign wr_take[i]    = wr_hit[i] & ~wr_blocked[i];

    guard_entry #(.RAW_W(RAW_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr_i),
      .cfg_we_i  (wr_take[i] & ~wr_sel_addr_i),
      .addr_we_i (wr_take[i] &  wr_sel_addr_i),
      .wdata_i   (wr_data_i),
      .cfg_o     (cfg_q),
      .addr_o    (addr_q)
    );

    assign cfg_o[i*CFG_W +: CFG_W]  = cfg_q;
    assign addr_o[i*RAW_W +: RAW_W] = addr_q;
  end

  assign wr_accept = |wr_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_done_o <= 1'b0;
      wr_ok_o   <= 1'b0;
    end else begin
      wr_done_o <= wr_en_i;
      wr_ok_o   <= wr_accept;
    end
  end

  guard_summary #(.NUM_ENT(NUM_ENT), .CNT_W(CNT_W)) u_sum (
    .cfg_i  (cfg_o),
    .cnt_o  (active_cnt_o),
    .lock_o (any_lock_o)
  );
endmodule

// File: rtl/guard_bank_chk.sv
module guard_bank_chk
  import guard_pkg::*;
#(
  parameter int NUM_ENT = 6,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clr_i,
  input logic                     wr_en_i,
  input logic [IDX_W-1:0]         wr_idx_i,
  input logic                     wr_sel_addr_i,
  input logic                     wr_done_o,
  input logic                     wr_ok_o,
  input logic [NUM_ENT*CFG_W-1:0] cfg_o,
  input logic [CNT_W-1:0]         active_cnt_o,
  input logic                     any_lock_o
);
  logic in_rng;
  logic tgt_locked;
  logic rsvd_any;

  assign in_rng = wr_idx_i < IDX_W'(NUM_ENT);

  always_comb begin
    tgt_locked = 1'b0;
    rsvd_any   = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (wr_idx_i == IDX_W'(i)) tgt_locked = cfg_o[i*CFG_W + 7];
      rsvd_any = rsvd_any | (|cfg_o[i*CFG_W + 5 +: 2]);
    end
  end

  a_r1_oob_reject: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !in_rng |=> wr_done_o && !wr_ok_o);

  a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !wr_sel_addr_i && in_rng && tgt_locked |=> !wr_ok_o);

  a_r3_addr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_sel_addr_i && in_rng && tgt_locked |=> !wr_ok_o);

  a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rsvd_any);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> wr_done_o);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> !wr_done_o && !wr_ok_o);

  a_r8_clear_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !any_lock_o && active_cnt_o == '0 && !wr_ok_o);

  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active_cnt_o <= CNT_W'(NUM_ENT));
endmodule

bind guard_bank guard_bank_chk #(
  .NUM_ENT (NUM_ENT),
  .IDX_W   (IDX_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clr_i         (clr_i),
  .wr_en_i       (wr_en_i),
  .wr_idx_i      (wr_idx_i),
  .wr_sel_addr_i (wr_sel_addr_i),
  .wr_done_o     (wr_done_o),
  .wr_ok_o       (wr_ok_o),
  .cfg_o         (cfg_o),
  .active_cnt_o  (active_cnt_o),
  .any_lock_o    (any_lock_o)
);

// File: tb/guard_bank_tb.sv
`timescale 1ns/1ps
module guard_bank_tb;
  localparam int N   = 6;
  localparam int RW  = 30;
  localparam int IW  = 4;
  localparam int CW  = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [IW-1:0] wr_idx_i = '0;
  logic          wr_sel_addr_i = 1'b0;
  logic [RW-1:0] wr_data_i = '0;
  logic          wr_done_o, wr_ok_o;
  logic [N*8-1:0]  cfg_o;
  logic [N*RW-1:0] addr_o;
  logic [CW-1:0]   active_cnt_o;
  logic            any_lock_o;

  guard_bank #(.NUM_ENT(N), .RAW_W(RW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .wr_en_i(wr_en_i),
    .wr_idx_i(wr_idx_i), .wr_sel_addr_i(wr_sel_addr_i), .wr_data_i(wr_data_i),
    .wr_done_o(wr_done_o), .wr_ok_o(wr_ok_o), .cfg_o(cfg_o), .addr_o(addr_o),
    .active_cnt_o(active_cnt_o), .any_lock_o(any_lock_o)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]    m_cfg  [N];
  logic [RW-1:0] m_addr [N];

  // vector: {sel_addr, idx[3:0], data[15:0], expected_ok}
  localparam int NV = 17;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 4'd0,  16'h0007, 1'b1},  // R5 plain permissions
    {1'b0, 4'd1,  16'h000F, 1'b1},  // R5 TOR unlocked
    {1'b1, 4'd0,  16'h0100, 1'b1},  // R6
    {1'b1, 4'd1,  16'h0200, 1'b1},  // R6
    {1'b0, 4'd1,  16'h008F, 1'b1},  // lock entry 1 in TOR
    {1'b1, 4'd0,  16'h0111, 1'b0},  // R4 locked TOR neighbour
    {1'b1, 4'd1,  16'h0222, 1'b0},  // R3 own lock
    {1'b0, 4'd1,  16'h0000, 1'b0},  // R2 cfg locked
    {1'b0, 4'd3,  16'h00FF, 1'b1},  // R5 reserved bits dropped
    {1'b1, 4'd2,  16'h0300, 1'b1},  // R4 locked NAPOT neighbour does not block
    {1'b0, 4'd4,  16'h0008, 1'b1},  // TOR unlocked
    {1'b1, 4'd3,  16'h0005, 1'b0},  // R3
    {1'b0, 4'd6,  16'h0007, 1'b0},  // R1 first index past end
    {1'b1, 4'd15, 16'h0001, 1'b0},  // R1 top index
    {1'b0, 4'd5,  16'h0090, 1'b1},  // lock last entry in NA4
    {1'b1, 4'd5,  16'h0ABC, 1'b0},  // R3 last entry
    {1'b1, 4'd4,  16'h0044, 1'b1}   // R4 locked NA4 neighbour does not block
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_accept(input logic sel, input int idx);
    if (idx >= N) return 1'b0;
    if (m_cfg[idx][7]) return 1'b0;
    if (sel && idx < N - 1 && m_cfg[idx+1][7] && m_cfg[idx+1][4:3] == 2'd1)
      return 1'b0;
    return 1'b1;
  endfunction

  task automatic check_state(input string req);
    int cnt = 0;
    logic lk = 1'b0;
    for (int i = 0; i < N; i++) begin
      chk(req, $sformatf("cfg[%0d]", i), 64'(cfg_o[i*8 +: 8]), 64'(m_cfg[i]));
      chk(req, $sformatf("addr[%0d]", i), 64'(addr_o[i*RW +: RW]), 64'(m_addr[i]));
      if (m_cfg[i][4:3] != 2'd0) cnt++;
      lk = lk | m_cfg[i][7];
    end
    chk("R9", "active count", 64'(active_cnt_o), 64'(cnt));
    chk("R9", "any lock", 64'(any_lock_o), 64'(lk));
  endtask

  // drive at negedge, the status and state are read at the next negedge
  task automatic do_write(input string req, input logic sel, input int idx,
                          input logic [RW-1:0] data, input logic clr,
                          input logic exp_ok_tab, input bit use_tab);
    logic ok;
    ok = clr ? 1'b0 : exp_accept(sel, idx);
    if (use_tab) chk(req, "table vs model", 64'(ok), 64'(exp_ok_tab));
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_addr_i = sel; wr_idx_i = IW'(idx);
    wr_data_i = data; clr_i = clr;
    @(negedge clk);
    wr_en_i = 1'b0; clr_i = 1'b0;
    if (clr) for (int i = 0; i < N; i++) m_cfg[i] = m_cfg[i] & 8'h67;
    if (ok) begin
      if (sel) m_addr[idx] = data;
      else     m_cfg[idx]  = {data[7], 2'b00, data[4:0]};
    end
    chk("R7", "done", 64'(wr_done_o), 64'd1);
    chk(req, "ok", 64'(wr_ok_o), 64'(ok));
    check_state(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_cfg[i] = '0; m_addr[i] = '0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "done", 64'(wr_done_o), 64'd0);
    chk("R10", "ok", 64'(wr_ok_o), 64'd0);
    check_state("R10");
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      do_write("R1-R6 vector", VEC[v][21], int'(VEC[v][20:17]),
               RW'(VEC[v][16:1]), 1'b0, VEC[v][0], 1'b1);
    end

    // R7 idle cycle: no status pulse
    @(negedge clk);
    chk("R7", "idle done", 64'(wr_done_o), 64'd0);
    chk("R7", "idle ok", 64'(wr_ok_o), 64'd0);

    // R6 full-width address on the last entry after clear
    // R8 clear with a simultaneous write to entry 0
    do_write("R8", 1'b0, 0, RW'(8'h8F), 1'b1, 1'b0, 1'b0);
    chk("R8", "cfg1 keeps perms", 64'(cfg_o[15:8]), 64'h07);
    chk("R8", "addr0 kept", 64'(addr_o[RW-1:0]), 64'h100);

    // former locks gone: writes now taken
    do_write("R8", 1'b1, 1, RW'(30'h2AAAAAAA), 1'b0, 1'b1, 1'b1);
    do_write("R6", 1'b1, 5, RW'(30'h3FFFFFFF), 1'b0, 1'b1, 1'b1);
    do_write("R4", 1'b1, 0, RW'(30'h00000123), 1'b0, 1'b1, 1'b1);

    // R4 last entry locked in TOR never blocks a neighbour beyond it
    do_write("R4", 1'b0, 5, RW'(8'h88), 1'b0, 1'b1, 1'b1);
    do_write("R4", 1'b1, 4, RW'(30'h55), 1'b0, 1'b0, 1'b1);
    do_write("R4", 1'b1, 3, RW'(30'h66), 1'b0, 1'b1, 1'b1);

    // R1 index equal to count on address side
    do_write("R1", 1'b1, N, RW'(30'h77), 1'b0, 1'b0, 1'b1);

    // R10 asynchronous reset returns everything to zero
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < N; i++) begin m_cfg[i] = '0; m_addr[i] = '0; end
    check_state("R10");
    chk("R10", "done after reset", 64'(wr_done_o), 64'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule